// File: doc/BRIEF.md
# Serial ADC Output Interface Model

This block models, in synthesizable form, the serial readback side of a successive-approximation converter that shares a host bus with other converters. A rising edge on the convert line while the select line is high starts a timed conversion and puts the data pin in its released state. When the timer runs out, the block takes the parallel sample on its input and holds it. The host then pulls select low to read the word out, MSB first, and the serial clock's falling edges step through the lower bits. All lines are sampled on the system clock `clk`. The serial clock is handled as a sampled data line and is not used as a clock.

The pin's high-impedance state is modelled by an explicit enable output, so a bench can put two instances on one wire and detect contention. Once a word has been read, any further read before a new conversion returns a fixed fill word instead of the sample. If select goes low while a conversion is running, a sticky error flag is set. Nothing else happens in response.

Top module: `sar_serial_out`

## Requirements
- R1: On a clock edge where convert is sampled high after being low and select is high, a conversion starts. From the next cycle the data enable is low, unless convert and select are both low.
- R2: Whenever convert and select are both low, the data enable is high and the data bit is 0, whatever the internal phase.
- R3: The sample input is captured on exactly the CONV_CYCLES-th clock edge after the start edge. A value present one edge earlier or one edge later is never the word read out.
- R4: When a captured word is ready, convert is high and select is sampled falling, the enable is high from the next cycle and the data bit shows bit 15 of the word.
- R5: During a read, each serial clock falling edge (sampled high, then low) moves the data bit to the next lower word bit, so 16 bits come out in descending order.
- R6: On the 16th serial clock falling edge of a read the enable goes low from the next cycle, provided convert is high.
- R7: Select sampled rising during a read, before the 16th falling edge, ends the read. The enable is low from the next cycle.
- R8: Every read after the first one following a conversion, including a read after one that was cut short, returns FILL_WORD MSB first and not the sample.
- R9: Select sampled low on any clock edge while a conversion is running sets the error flag. Only reset clears it. Reads with correct protocol leave it at 0.
- R10: After reset and before any conversion, a select falling edge with convert high leaves the enable low. A convert rising edge with select low starts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; every input line is sampled on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| conv_i | input | 1 | Convert line |
| sel_i | input | 1 | Active-low select line |
| sclk_i | input | 1 | Serial clock, sampled as data |
| sample_i | input | DATA_W | Parallel result captured when conversion ends |
| sdo_o | output | 1 | Serial data bit, meaningful when enabled |
| sdo_en_o | output | 1 | 1 = data pin driven, 0 = high impedance |
| proto_err_o | output | 1 | Sticky flag: select went low during conversion |

## Verification
The sweep runs walking-one and walking-zero words, all-zero, all-one and alternating words, plus a set of words from a computed pseudo-random sequence. This checks every bit position in both polarities, so a stuck, swapped or off-by-one shift stage cannot go unseen. During each conversion the sample input holds the complement of the intended word on the edges before and after the capture edge, so capture one cycle early or late is exposed. The bench cuts reads short after every possible count of falling edges from 0 to 15, which separates early release from release on the 16th edge. The read after each cut-short read must return the fill word. Separate sequences cover driving low when both lines are low, select before any conversion, and select low during conversion, which sets the error flag.

// File: rtl/sar_out_pkg.sv
// Package: shared types for the serial ADC output model.
// Assumes nothing beyond IEEE 1800-2017.
package sar_out_pkg;

    // Operating phase of the readback controller
    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,   // no result held since reset
        PH_CONV  = 3'd1,   // conversion timer running
        PH_READY = 3'd2,   // fresh result waiting for a read
        PH_READ  = 3'd3,   // word being shifted out
        PH_SPENT = 3'd4    // result consumed, fill word armed
    } phase_t;

endpackage

// File: rtl/sar_edge_det.sv
// Module: sar_edge_det
// Registers a vector of sampled lines and flags, per bit, rising and
// falling transitions between the previous and current sample.
// Assumes the inputs are already synchronous to clk.
module sar_edge_det #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lines_i,
    output logic [W-1:0] rise_o,
    output logic [W-1:0] fall_o
);
    logic [W-1:0] prev_q;

    for (genvar b = 0; b < W; b++) begin : g_line
        // Hold the previous sample of this line
        always_ff @(posedge clk) begin
            if (!rst_n) prev_q[b] <= 1'b0;
            else        prev_q[b] <= lines_i[b];
        end
        assign rise_o[b] =  lines_i[b] & ~prev_q[b];
        assign fall_o[b] = ~lines_i[b] &  prev_q[b];
    end
endmodule

// File: rtl/sar_conv_timer.sv
// Module: sar_conv_timer
// Counts the conversion time. A start loads the count, and expire_o
// pulses on the CONV_CYCLES-th edge after the start while run_i is held.
// Assumes CONV_CYCLES >= 1.
module sar_conv_timer #(
    parameter int CONV_CYCLES = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic run_i,
    output logic expire_o
);
    localparam int CW = $clog2(CONV_CYCLES + 1);
    localparam logic [CW-1:0] LOAD_VAL = CW'(CONV_CYCLES - 1);

    logic [CW-1:0] cnt_q;

    // Load on start, count down while the conversion runs
    always_ff @(posedge clk) begin
        if (!rst_n)                          cnt_q <= '0;
        else if (start_i)                    cnt_q <= LOAD_VAL;
        else if (run_i && cnt_q != '0)       cnt_q <= cnt_q - 1'b1;
    end

    assign expire_o = run_i && !start_i && (cnt_q == '0);
endmodule

// File: rtl/sar_readback_shift.sv
// Module: sar_readback_shift
// Holds the word to be read, presents its MSB and shifts left on each
// step. After a read ends it is refilled with FILL_WORD. A bit counter
// flags the step that moves out the last bit.
// Assumes only one of load/refill/shift/begin matters per cycle (that
// order of priority).
module sar_readback_shift #(
    parameter int              DATA_W    = 16,
    parameter logic [DATA_W-1:0] FILL_WORD = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [DATA_W-1:0] sample_i,
    input  logic              refill_i,
    input  logic              shift_i,
    input  logic              begin_i,
    output logic              msb_o,
    output logic              last_o
);
    localparam int BW = $clog2(DATA_W);
    localparam logic [BW-1:0] LAST_IDX = BW'(DATA_W - 1);

    logic [DATA_W-1:0] word_q;
    logic [BW-1:0]     bit_q;

    // Word register: capture, refill or shift
    always_ff @(posedge clk) begin
        if (!rst_n)        word_q <= FILL_WORD;
        else if (load_i)   word_q <= sample_i;
        else if (refill_i) word_q <= FILL_WORD;
        else if (shift_i)  word_q <= {word_q[DATA_W-2:0], 1'b0};
    end

    // Bit counter: cleared at each read start, advanced per shift
    always_ff @(posedge clk) begin
        if (!rst_n)                  bit_q <= '0;
        else if (load_i || begin_i)  bit_q <= '0;
        else if (shift_i)            bit_q <= bit_q + 1'b1;
    end

    assign msb_o  = word_q[DATA_W-1];
    assign last_o = shift_i && (bit_q == LAST_IDX);
endmodule

// File: rtl/sar_serial_out.sv
// Module: sar_serial_out (top)
// Serial output side of a converter in select-per-device 4-wire mode.
// Convert rising with select high starts a timed conversion; afterwards
// select low reads the word out MSB first, advanced by serial clock
// falling edges. Reads end on the 16th fall or on select rising.
// Assumes conv_i, sel_i and sclk_i are synchronous to clk.
module sar_serial_out
    import sar_out_pkg::*;
#(
    parameter int                DATA_W      = 16,
    parameter int                CONV_CYCLES = 8,
    parameter logic [DATA_W-1:0] FILL_WORD   = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              conv_i,
    input  logic              sel_i,
    input  logic              sclk_i,
    input  logic [DATA_W-1:0] sample_i,
    output logic              sdo_o,
    output logic              sdo_en_o,
    output logic              proto_err_o
);
    localparam int LN_CONV = 0;
    localparam int LN_SEL  = 1;
    localparam int LN_SCK  = 2;
    localparam int N_LINES = 3;

    logic [N_LINES-1:0] rise, fall;
    phase_t phase_q, phase_d;
    logic   start, expire, cap, rd_begin, rd_shift, rd_end, last_bit, msb;
    logic   err_q, both_low, reading;

    sar_edge_det #(.W(N_LINES)) u_edges (
        .clk     (clk),
        .rst_n   (rst_n),
        .lines_i ({sclk_i, sel_i, conv_i}),
        .rise_o  (rise),
        .fall_o  (fall)
    );

    assign start = rise[LN_CONV] && sel_i;

    sar_conv_timer #(.CONV_CYCLES(CONV_CYCLES)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start),
        .run_i    (phase_q == PH_CONV),
        .expire_o (expire)
    );

    assign reading  = (phase_q == PH_READ);
    assign cap      = expire;
    assign rd_begin = !start && conv_i && fall[LN_SEL] &&
                      (phase_q == PH_READY || phase_q == PH_SPENT);
    assign rd_shift = reading && fall[LN_SCK] && !rise[LN_SEL];
    assign rd_end   = reading && (rise[LN_SEL] || last_bit);

    sar_readback_shift #(.DATA_W(DATA_W), .FILL_WORD(FILL_WORD)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (cap),
        .sample_i (sample_i),
        .refill_i (rd_end),
        .shift_i  (rd_shift),
        .begin_i  (rd_begin),
        .msb_o    (msb),
        .last_o   (last_bit)
    );

    // Next-phase selection
    always_comb begin
        phase_d = phase_q;
        if (start) begin
            phase_d = PH_CONV;
        end else begin
            unique case (phase_q)
                PH_CONV:            if (expire)   phase_d = PH_READY;
                PH_READY, PH_SPENT: if (rd_begin) phase_d = PH_READ;
                PH_READ:            if (rd_end)   phase_d = PH_SPENT;
                default:            phase_d = phase_q;
            endcase
        end
    end

    // Phase register
    always_ff @(posedge clk) begin
        if (!rst_n) phase_q <= PH_IDLE;
        else        phase_q <= phase_d;
    end

    // Sticky protocol error: select low while converting
    always_ff @(posedge clk) begin
        if (!rst_n)                                      err_q <= 1'b0;
        else if (phase_q == PH_CONV && !sel_i && !start) err_q <= 1'b1;
    end

    assign both_low    = !conv_i && !sel_i;
    assign sdo_en_o    = reading || both_low;
    assign sdo_o       = reading && !both_low && msb;
    assign proto_err_o = err_q;
endmodule

// File: rtl/sar_serial_out_checker.sv
// Module: sar_serial_out_checker
// Port-level properties of the serial output model, bound to the top.
// Assumes DATA_W falling edges make a full read.
module sar_serial_out_checker #(
    parameter int DATA_W = 16
) (
    input logic clk,
    input logic rst_n,
    input logic conv_i,
    input logic sel_i,
    input logic sclk_i,
    input logic sdo_o,
    input logic sdo_en_o,
    input logic proto_err_o
);
    localparam int FW = $clog2(DATA_W + 1) + 1;

    logic          sck_prev;
    logic [FW-1:0] falls_q;

    // Track previous serial clock sample for fall detection
    always_ff @(posedge clk) begin
        if (!rst_n) sck_prev <= 1'b0;
        else        sck_prev <= sclk_i;
    end

    // Count serial clock falls seen while a read is on the bus
    always_ff @(posedge clk) begin
        if (!rst_n || !sdo_en_o || sel_i) falls_q <= '0;
        else if (sck_prev && !sclk_i)     falls_q <= falls_q + 1'b1;
    end

    assert_start_release_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(conv_i) && sel_i) |=> (!sdo_en_o || (!conv_i && !sel_i)));

    assert_both_low_drive_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!conv_i && !sel_i) |-> (sdo_en_o && !sdo_o));

    assert_full_read_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (falls_q == FW'(DATA_W) && conv_i) |-> !sdo_en_o);

    assert_fall_count_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        falls_q <= FW'(DATA_W));

    assert_select_high_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_i && $past(sel_i)) |-> !sdo_en_o);

    assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        proto_err_o |=> proto_err_o);
endmodule

bind sar_serial_out sar_serial_out_checker #(.DATA_W(DATA_W)) u_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .conv_i      (conv_i),
    .sel_i       (sel_i),
    .sclk_i      (sclk_i),
    .sdo_o       (sdo_o),
    .sdo_en_o    (sdo_en_o),
    .proto_err_o (proto_err_o)
);

// File: tb/sar_serial_out_bench.sv
// Bench: sweeps words through conversion and readback, full and cut-short
// reads, fill-word reads, driving low and protocol-error cases.
module sar_serial_out_bench;
    localparam int          CLK_PERIOD = 10;
    localparam int          DW         = 16;
    localparam int          NCONV      = 5;
    localparam logic [15:0] FILL       = 16'hC3A5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          conv = 1'b0, sel = 1'b1, sck = 1'b0;
    logic [DW-1:0] sample = '0;
    logic          sdo, sdo_en, err;
    int            n_cmp = 0, n_bad = 0;
    bit            done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sar_serial_out #(.DATA_W(DW), .CONV_CYCLES(NCONV), .FILL_WORD(FILL)) u_sar_serial_out (
        .clk(clk), .rst_n(rst_n), .conv_i(conv), .sel_i(sel), .sclk_i(sck),
        .sample_i(sample), .sdo_o(sdo), .sdo_en_o(sdo_en), .proto_err_o(err)
    );

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Run one conversion with word w captured on the NCONV-th edge (R1, R3)
    task automatic convert(input logic [15:0] w);
        sample = ~w;
        conv = 1'b1;
        step();
        check("R1 enable after start", {15'd0, sdo_en}, 16'd0);
        repeat (NCONV - 1) step();
        sample = w;
        step();
        sample = ~w;
    endtask

    // Read up to n falls; checks bits of expected word exp (R4, R5, R6)
    task automatic read_word(input logic [15:0] exp, input int n, input string tag);
        sel = 1'b0;
        step();
        check({tag, " R4 enable"}, {15'd0, sdo_en}, 16'd1);
        check({tag, " R4 msb"}, {15'd0, sdo}, {15'd0, exp[15]});
        for (int i = 0; i < n; i++) begin
            sck = 1'b1; step();
            sck = 1'b0; step();
            if (i < DW - 1) begin
                check({tag, " R5 bit"}, {15'd0, sdo}, {15'd0, exp[14-i]});
                check({tag, " R5 enable"}, {15'd0, sdo_en}, 16'd1);
            end else begin
                check({tag, " R6 release"}, {15'd0, sdo_en}, 16'd0);
            end
        end
    endtask

    function automatic logic [15:0] pattern(input int k);
        logic [15:0] v;
        if (k < 16)       v = 16'h1 << k;
        else if (k < 32)  v = ~(16'h1 << (k - 16));
        else begin
            case (k)
                32: v = 16'h0000;
                33: v = 16'hFFFF;
                34: v = 16'hAAAA;
                35: v = 16'h5555;
                default: v = 16'(((k * 40503) ^ (k << 9)) + 16'h1D2B);
            endcase
        end
        return v;
    endfunction

    initial begin
        repeat (3) step();
        check("R9 reset err", {15'd0, err}, 16'd0);
        check("R2 reset enable", {15'd0, sdo_en}, 16'd0);
        rst_n = 1'b1;
        step();

        // R2: both low drives 0
        sel = 1'b0; #1;
        check("R2 enable", {15'd0, sdo_en}, 16'd1);
        check("R2 data", {15'd0, sdo}, 16'd0);
        step();
        // R10: convert rise with select low, then select fall, no read
        conv = 1'b1; step();
        sel = 1'b1; step();
        sel = 1'b0; step();
        check("R10 no read before conversion", {15'd0, sdo_en}, 16'd0);
        conv = 1'b0; sel = 1'b1; step();

        // Full reads and a fill-word read for each word (R3..R8)
        for (int k = 0; k < 44; k++) begin
            logic [15:0] w;
            w = pattern(k);
            convert(w);
            read_word(w, DW, "R3 word");
            sel = 1'b1; step();
            read_word(FILL, DW, "R8 fill");
            sel = 1'b1; step();
            conv = 1'b0; step();
        end

        // Cut-short reads after every count of falls (R7, R8)
        for (int n = 0; n < DW; n++) begin
            logic [15:0] w;
            w = pattern(40 + n);
            convert(w);
            read_word(w, n, "R7 part");
            sel = 1'b1; step();
            check("R7 early release", {15'd0, sdo_en}, 16'd0);
            read_word(FILL, 1, "R8 after cut");
            sel = 1'b1; step();
            conv = 1'b0; step();
        end
        check("R9 no error on clean reads", {15'd0, err}, 16'd0);

        // R9: select low during conversion sets sticky error
        conv = 1'b1; step();
        sel = 1'b0; step();
        check("R9 err set", {15'd0, err}, 16'd1);
        sel = 1'b1; repeat (NCONV + 2) step();
        conv = 1'b0; step();
        check("R9 err sticky", {15'd0, err}, 16'd1);

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule